// File: doc/BRIEF.md
# I2C Register-Bank Slave

This block is an I2C-compatible target that runs entirely on a fast system clock. It synchronizes the SCL and SDA lines and finds their edges. From these it detects START and STOP, matches a fixed 7-bit device address, and acknowledges every accepted byte on the ninth clock. The block only ever pulls SDA low or lets it float high. It drives SDA through an open-drain enable and relies on external pull-ups for the high level.

Behind the bus sits a 16-entry, 8-bit register file. In a write transaction the first byte after the address loads a register pointer. Every later byte is stored at that pointer, and the pointer then advances. A read transaction shifts out the register at the pointer and advances the pointer after each byte the master acknowledges. The rest of the chip reads the register file through a separate read port. A one-cycle strobe, together with the address and data, announces each register update.

The control is one state machine with these states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`: receiving the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_PTR` and `ST_PTR_ACK`: receiving and acknowledging the pointer byte.
- `ST_WDATA` and `ST_WDATA_ACK`: receiving and acknowledging a write data byte.
- `ST_RDATA` and `ST_RDATA_ACK`: sending a byte and sampling the master's answer.
- `ST_IGNORE`: deaf until the next START or STOP.

These transitions take priority over all others:
- STOP moves any state to `ST_IDLE`.
- START moves any state to `ST_ADDR`.

The remaining transitions happen at SCL falling edges:
- `ST_ADDR` goes to `ST_ADDR_ACK` on an address match, or to `ST_IGNORE` on a mismatch.
- `ST_ADDR_ACK` goes to `ST_PTR` for a write or to `ST_RDATA` for a read.
- `ST_PTR` goes to `ST_PTR_ACK`, then to `ST_WDATA`.
- `ST_WDATA` goes to `ST_WDATA_ACK`, then back to `ST_WDATA`.
- `ST_RDATA` goes to `ST_RDATA_ACK`, then back to `ST_RDATA` if the master acknowledged, or to `ST_IGNORE` if it did not.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset, `sda_oe` and `wr_stb` are 0 and all 16 registers read 0x00.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A STOP in the middle of a byte abandons that byte, so no register changes and no strobe occurs.
- R3: The first byte after START holds the address bits MSB first and then a direction bit, where 0 means write and 1 means read. When the address bits equal 1100000, the block holds SDA low through the high phase of the ninth SCL clock.
- R4: On any other address the block does not acknowledge. It leaves SDA released and ignores all bytes until the next START.
- R5: In a write, the byte after the address is the pointer and is acknowledged. Each following byte is acknowledged and stored at the pointer. Each stored byte produces exactly one one-cycle `wr_stb` with `wr_addr` and `wr_data`, and the pointer then advances by one.
- R6: The pointer wraps modulo 16, so a byte written at pointer 15 is followed by one at pointer 0.
- R7: A pointer byte with any of bits 7..4 set is still acknowledged, as are its data bytes. Those data bytes update no register and produce no strobe.
- R8: In a read, the block sends the register at the pointer MSB first. The pointer persists from an earlier transaction and advances after each byte the master acknowledges.
- R9: After the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next START or STOP.
- R10: A START without a preceding STOP returns the block to address matching, and the new transaction behaves like a fresh one.
- R11: `sda_oe` changes only while the synchronized SCL is low.
- R12: A read while the pointer came from an out-of-range pointer byte returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_addr | input | 4 | Register file read address for the rest of the chip |
| rd_data | output | 8 | Register contents at `rd_addr` |
| wr_stb | output | 1 | One-cycle pulse for each register written from the bus |
| wr_addr | output | 4 | Register index of the write announced by `wr_stb` |
| wr_data | output | 8 | Value of the write announced by `wr_stb` |

## Verification
The hardest situations to reach from the ports are mid-transaction breaks. The first is a STOP that lands after only a few bits of a data byte. The second is a START with no STOP before it, in both write and read directions. These can only be produced by a bench master that drives SCL and SDA bit by bit rather than by whole bytes. The bench therefore has separate bit, byte, START and STOP tasks. It composes these directed breaks alongside random pointers, which sometimes fall out of range, and random burst lengths. All results are compared against a register-file model kept in the bench.

// File: rtl/i2c_rb_pkg.sv
`timescale 1ns/1ps
package i2c_rb_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } slv_state_t;
endpackage

// File: rtl/i2c_rb_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer with edge flags on the synchronized level.
module i2c_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], pin};
        end
    end

    assign level = pipe_q[STAGES-1];
    assign rise  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/i2c_rb_regfile.sv
`timescale 1ns/1ps
// Register file: one write port, two asynchronous read ports.
module i2c_rb_regfile #(
    parameter  int DEPTH = 16,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (we && (waddr == AW'(g))) begin
                mem_q[g] <= wdata;
            end
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/i2c_regbank_slave.sv
`timescale 1ns/1ps
module i2c_regbank_slave
    import i2c_rb_pkg::*;
#(
    parameter  logic [6:0] DEV_ADDR  = 7'b1100000,
    parameter  int         REG_COUNT = 16,
    parameter  int         SYNC_STG  = 2,
    localparam int         PTR_W     = $clog2(REG_COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [7:0]       rd_data,
    output logic             wr_stb,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_data
);
    logic scl_lvl, scl_r, scl_f;
    logic sda_lvl, sda_r, sda_f;

    i2c_rb_sync #(.STAGES(SYNC_STG)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .pin(scl_in),
        .level(scl_lvl), .rise(scl_r), .fall(scl_f)
    );
    i2c_rb_sync #(.STAGES(SYNC_STG)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .pin(sda_in),
        .level(sda_lvl), .rise(sda_r), .fall(sda_f)
    );

    slv_state_t       state_q, state_d;
    logic [3:0]       cnt_q;
    logic [7:0]       shreg_q;
    logic [PTR_W-1:0] ptr_q;
    logic             ptr_ok_q;
    logic             rw_q;
    logic             mack_q;
    logic [7:0]       bank_rd;
    logic [7:0]       tx_byte;

    wire start_c   = sda_f & scl_lvl;
    wire stop_c    = sda_r & scl_lvl;
    wire byte_done = scl_f & (cnt_q == 4'd8);
    wire addr_hit  = (shreg_q[7:1] == DEV_ADDR);

    assign tx_byte = ptr_ok_q ? bank_rd : 8'hFF;

    i2c_rb_regfile #(.DEPTH(REG_COUNT), .DW(8)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .we(wr_stb), .waddr(wr_addr), .wdata(wr_data),
        .raddr_a(rd_addr), .rdata_a(rd_data),
        .raddr_b(ptr_q), .rdata_b(bank_rd)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (stop_c) begin
            state_d = ST_IDLE;
        end else if (start_c) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_ADDR:      if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_f)     state_d = rw_q ? ST_RDATA : ST_PTR;
                ST_PTR:       if (byte_done) state_d = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_f)     state_d = ST_WDATA;
                ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_f)     state_d = ST_WDATA;
                ST_RDATA:     if (byte_done) state_d = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_f)     state_d = mack_q ? ST_RDATA : ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            shreg_q  <= '0;
            ptr_q    <= '0;
            ptr_ok_q <= 1'b1;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            sda_oe   <= 1'b0;
            wr_stb   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (stop_c || start_c) begin
                cnt_q  <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (scl_r && (cnt_q < 4'd8)) begin
                            shreg_q <= {shreg_q[6:0], sda_lvl};
                            cnt_q   <= cnt_q + 4'd1;
                        end else if (byte_done) begin
                            cnt_q <= '0;
                            if (state_q == ST_ADDR) begin
                                if (addr_hit) begin
                                    sda_oe <= 1'b1;
                                    rw_q   <= shreg_q[0];
                                end
                            end else if (state_q == ST_PTR) begin
                                sda_oe   <= 1'b1;
                                ptr_q    <= shreg_q[PTR_W-1:0];
                                ptr_ok_q <= (shreg_q[7:PTR_W] == '0);
                            end else begin
                                sda_oe  <= 1'b1;
                                wr_stb  <= ptr_ok_q;
                                wr_addr <= ptr_q;
                                wr_data <= shreg_q;
                                ptr_q   <= ptr_q + 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_f) begin
                            if (rw_q) begin
                                shreg_q <= tx_byte;
                                sda_oe  <= ~tx_byte[7];
                            end else begin
                                sda_oe  <= 1'b0;
                            end
                        end
                    end
                    ST_PTR_ACK, ST_WDATA_ACK: begin
                        if (scl_f) sda_oe <= 1'b0;
                    end
                    ST_RDATA: begin
                        if (scl_r) begin
                            cnt_q <= cnt_q + 4'd1;
                        end else if (scl_f) begin
                            if (cnt_q == 4'd8) begin
                                cnt_q  <= '0;
                                sda_oe <= 1'b0;
                            end else begin
                                shreg_q <= {shreg_q[6:0], 1'b0};
                                sda_oe  <= ~shreg_q[6];
                            end
                        end
                    end
                    ST_RDATA_ACK: begin
                        if (scl_r) begin
                            mack_q <= ~sda_lvl;
                            if (!sda_lvl) ptr_q <= ptr_q + 1'b1;
                        end else if (scl_f) begin
                            if (mack_q) begin
                                shreg_q <= tx_byte;
                                sda_oe  <= ~tx_byte[7];
                            end else begin
                                sda_oe  <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_regbank_chk.sv
`timescale 1ns/1ps
module i2c_regbank_chk
    import i2c_rb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input slv_state_t state,
    input logic       sda_oe,
    input logic       wr_stb
);
    AST_OE_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe)); // R11

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe); // R4

    AST_RX_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR || state == ST_PTR || state == ST_WDATA) |-> !sda_oe); // R3

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R5

    AST_STB_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (state == ST_WDATA_ACK && sda_oe)); // R5
endmodule

bind i2c_regbank_slave i2c_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl),
    .state(state_q), .sda_oe(sda_oe), .wr_stb(wr_stb)
);

// File: tb/tb_i2c_regbank_slave.sv
`timescale 1ns/1ps
module tb_i2c_regbank_slave;
    localparam int         Q   = 12;
    localparam logic [6:0] DEV = 7'b1100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic [3:0] rd_addr = '0;
    logic sda_oe, wr_stb;
    logic [7:0] rd_data, wr_data;
    logic [3:0] wr_addr;
    logic sda_line;

    always #10 clk = ~clk;
    assign sda_line = ~(m_low | sda_oe);

    i2c_regbank_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int checks = 0, fails = 0, stb_seen = 0, exp_stb = 0;
    logic [7:0] exp_mem [16];
    logic [7:0] wbuf [16];
    logic [3:0] eptr = '0;
    bit eok = 1'b1;
    bit done = 1'b0;

    always @(negedge clk) if (rst_n && wr_stb) stb_seen++;

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        m_low = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
        m_low = 1'b1; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic m_stop();
        m_low = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        m_low = 1'b0; wq(Q);
    endtask

    task automatic m_bit(input bit b);
        m_low = ~b; wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic m_send(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) m_bit(b[i]);
        m_low = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
        ack = !sda_line;
        wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic m_recv(input bit ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); m_scl = 1'b1; wq(Q); b[i] = sda_line; wq(Q); m_scl = 1'b0; wq(Q);
        end
        m_bit(!ack);
        m_low = 1'b0;
    endtask

    function automatic logic [7:0] exp_rd();
        return eok ? exp_mem[eptr] : 8'hFF;
    endfunction

    task automatic wr_txn(input logic [6:0] dev, input logic [7:0] p, input int n, input string req);
        bit a;
        m_start();
        m_send({dev, 1'b0}, a);
        if (dev != DEV) begin
            chk(!a, "R4", 32'(a), 0);
            m_send(p, a);
            chk(!a, "R4", 32'(a), 0);
            for (int i = 0; i < n; i++) begin
                m_send(wbuf[i], a);
                chk(!a, "R4", 32'(a), 0);
            end
        end else begin
            chk(a, "R3", 32'(a), 1);
            m_send(p, a);
            chk(a, req, 32'(a), 1);
            eptr = p[3:0];
            eok  = (p[7:4] == 4'h0);
            for (int i = 0; i < n; i++) begin
                m_send(wbuf[i], a);
                chk(a, req, 32'(a), 1);
                if (eok) begin
                    exp_mem[eptr] = wbuf[i];
                    exp_stb++;
                end
                eptr = eptr + 4'd1;
            end
        end
        m_stop();
        wq(4);
        chk(stb_seen == exp_stb, req, 32'(stb_seen), 32'(exp_stb));
    endtask

    task automatic rd_txn(input int n);
        bit a;
        logic [7:0] b, e;
        m_start();
        m_send({DEV, 1'b1}, a);
        chk(a, "R8", 32'(a), 1);
        for (int i = 0; i < n; i++) begin
            e = exp_rd();
            m_recv(i < n - 1, b);
            chk(b == e, eok ? "R8" : "R12", 32'(b), 32'(e));
            if (i < n - 1) eptr = eptr + 4'd1;
        end
        m_stop();
    endtask

    task automatic verify_bank(input string req);
        for (int k = 0; k < 16; k++) begin
            rd_addr = 4'(k);
            wq(2);
            chk(rd_data == exp_mem[k], req, 32'(rd_data), 32'(exp_mem[k]));
        end
    endtask

    initial begin
        bit a;
        logic [7:0] b;
        logic [7:0] p;
        int n;
        void'($urandom(32'd2024));
        for (int k = 0; k < 16; k++) exp_mem[k] = 8'h00;
        wq(5);
        chk(sda_oe == 1'b0, "R1", 32'(sda_oe), 0);
        chk(wr_stb == 1'b0, "R1", 32'(wr_stb), 0);
        rst_n = 1'b1;
        wq(5);
        verify_bank("R1");

        // Burst write from pointer 0
        wbuf[0] = 8'h0E; wbuf[1] = 8'hD8; wbuf[2] = 8'hE1;
        wr_txn(DEV, 8'h00, 3, "R5");
        verify_bank("R5");

        // Wrong address: nothing acknowledged, nothing stored
        wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
        wr_txn(7'b1100001, 8'h01, 2, "R4");
        verify_bank("R4");

        // Pointer wrap past 15
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        wr_txn(DEV, 8'h0E, 4, "R6");
        verify_bank("R6");

        // Out-of-range pointer: ACKed, discarded, reads 0xFF
        wbuf[0] = 8'h5A; wbuf[1] = 8'hA5;
        wr_txn(DEV, 8'h23, 2, "R7");
        verify_bank("R7");
        rd_txn(2);

        // Read burst with pointer set by prior write, then NACK release
        wr_txn(DEV, 8'h0F, 0, "R8");
        m_start();
        m_send({DEV, 1'b1}, a);
        chk(a, "R8", 32'(a), 1);
        for (int i = 0; i < 3; i++) begin
            logic [7:0] e;
            e = exp_rd();
            m_recv(i < 2, b);
            chk(b == e, "R8", 32'(b), 32'(e));
            if (i < 2) eptr = eptr + 4'd1;
        end
        m_low = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
        chk(sda_line == 1'b1, "R9", 32'(sda_line), 1);
        chk(sda_oe == 1'b0, "R9", 32'(sda_oe), 0);
        wq(Q); m_scl = 1'b0; wq(Q);
        m_stop();

        // Repeated START inside a write
        m_start();
        m_send({DEV, 1'b0}, a); m_send(8'h07, a); m_send(8'h55, a);
        m_start();
        m_send({DEV, 1'b0}, a);
        chk(a, "R10", 32'(a), 1);
        m_send(8'h09, a); m_send(8'h66, a);
        chk(a, "R10", 32'(a), 1);
        m_stop();
        exp_mem[7] = 8'h55; exp_mem[9] = 8'h66; exp_stb += 2; eptr = 4'd10; eok = 1'b1;
        wq(4);
        chk(stb_seen == exp_stb, "R10", 32'(stb_seen), 32'(exp_stb));
        verify_bank("R10");

        // Repeated START turning a write into a read
        m_start();
        m_send({DEV, 1'b0}, a); m_send(8'h07, a);
        m_start();
        m_send({DEV, 1'b1}, a);
        chk(a, "R10", 32'(a), 1);
        m_recv(1'b0, b);
        chk(b == 8'h55, "R10", 32'(b), 32'h55);
        m_stop();
        eptr = 4'd7;

        // STOP after four bits of a data byte
        m_start();
        m_send({DEV, 1'b0}, a); m_send(8'h02, a);
        m_bit(1'b1); m_bit(1'b0); m_bit(1'b1); m_bit(1'b1);
        m_stop();
        eptr = 4'd2; eok = 1'b1;
        wq(4);
        chk(stb_seen == exp_stb, "R2", 32'(stb_seen), 32'(exp_stb));
        verify_bank("R2");

        // Random traffic
        for (int t = 0; t < 10; t++) begin
            if ($urandom % 6 == 0) p = 8'h10 + 8'($urandom % 200);
            else                   p = 8'($urandom % 16);
            n = 1 + int'($urandom % 4);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            wr_txn(DEV, p, n, p[7:4] == 4'h0 ? "R5" : "R7");
            wr_txn(DEV, 8'($urandom % 16), 0, "R8");
            rd_txn(1 + int'($urandom % 3));
        end
        verify_bank("R5");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired got=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule